// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of the cache lines a non-blocking cache has asked memory for and not yet received. Each miss lookup carries a line address and a requester tag. When the line is not already pending, a free entry is claimed, the tag is stored as its first waiter, and one request goes out to memory. When the line is already pending, the tag is appended to that entry and no new request is made. The cache can therefore keep serving hits and issuing further misses while earlier ones are still in flight.

When memory answers with a fill for a pending line, the entry is marked as filled. A small wakeup state machine then replays every stored tag, one per accepted handshake, and releases the entry after the last one. The machine has two states. In WK_IDLE it waits for any filled entry, picks the lowest-numbered one and resets its read pointer (transition "pick"). In WK_SEND it drives the wakeup port. Each accepted handshake either advances the pointer ("advance") or, on the final waiter, frees the entry and returns to WK_IDLE ("release"). A stall output tells the cache when a lookup cannot be taken this cycle.

Top module: `mshr_file`

## Requirements
- R1: An accepted lookup whose line matches no valid entry claims the lowest-numbered free entry. In the cycle after the accepting clock edge, `mem_req_valid` is high for exactly one cycle with `mem_req_addr` equal to the lookup's line address.
- R2: An accepted lookup whose line matches a valid entry adds its tag to that entry and produces no memory request. At most one valid entry ever holds a given line.
- R3: A fill for a pending line causes every tag stored in that entry to be woken. After the last tag is woken the entry is free and can be claimed by a new line.
- R4: A lookup that matches an entry already holding `N_WAIT` tags raises `lk_stall` in the same cycle.
- R5: A lookup for a new line while all `N_ENTRIES` entries are valid raises `lk_stall` in the same cycle.
- R6: New primary misses are accepted and issued to memory while earlier misses are still outstanding, up to `N_ENTRIES` lines at once.
- R7: Tags are woken in the order their lookups were accepted, one per clock edge on which `wk_valid` and `wk_ready` are both high. While `wk_ready` is low, `wk_valid` stays high and `wk_tag` is held.
- R8: A lookup and a fill for the same pending line in the same cycle are handled by merging first. The new tag is therefore woken as well, after the tags stored earlier.
- R9: A fill whose line matches no pending, unfilled entry has no effect: no tag is woken.
- R10: A lookup presented while `lk_stall` is high has no effect: it issues no request and its tag is never woken.
- R11: The waiters of one entry are woken back to back. Tags of different entries never interleave, and an entry filled while another is draining is woken after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Miss lookup present |
| lk_addr | input | ADDR_W | Line address of the lookup |
| lk_tag | input | TAG_W | Requester tag of the lookup |
| lk_stall | output | 1 | Lookup cannot be accepted this cycle |
| mem_req_valid | output | 1 | One-cycle memory request for a new line |
| mem_req_addr | output | ADDR_W | Line address of the memory request |
| fill_valid | input | 1 | Memory fill response present |
| fill_addr | input | ADDR_W | Line address of the fill |
| wk_valid | output | 1 | Wakeup tag present |
| wk_ready | input | 1 | Consumer accepts the wakeup tag |
| wk_tag | output | TAG_W | Requester tag being woken |

## Verification
The assertions check four things on every cycle. An accepted primary miss is always followed by a request, and a merge never is. No two valid entries share a line. Full storage always stalls a new line. The wakeup tag stays stable under backpressure. Only the bench's scenarios can show the end-to-end effects: the full wakeup sequence after a fill, arrival order, the merge that happens in the same cycle as a fill, entry reuse after release, and that stalled lookups and stray fills leave no trace. The bench checks each of these by comparing logged requests and wakeups with sequences it computes itself.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    typedef enum logic [0:0] {
        WK_IDLE = 1'b0,
        WK_SEND = 1'b1
    } wk_state_e;
endpackage

// File: rtl/mshr_cam.sv
module mshr_cam #(
    parameter int N_ENTRIES = 16,
    parameter int ADDR_W    = 26,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0] ent_valid,
    input  logic [ADDR_W-1:0]    ent_addr [N_ENTRIES],
    input  logic [N_ENTRIES-1:0] ent_filled,
    input  logic [ADDR_W-1:0]    lk_addr,
    input  logic [ADDR_W-1:0]    fill_addr,
    output logic [N_ENTRIES-1:0] lk_hit_vec,
    output logic                 lk_hit,
    output logic [IW-1:0]        lk_hit_idx,
    output logic [N_ENTRIES-1:0] fill_hit_vec,
    output logic                 free_found,
    output logic [IW-1:0]        free_idx
);
    // Fully associative compare; scanning downward lets the lowest index win.
    always_comb begin
        lk_hit       = 1'b0;
        lk_hit_idx   = '0;
        free_found   = 1'b0;
        free_idx     = '0;
        lk_hit_vec   = '0;
        fill_hit_vec = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            lk_hit_vec[i]   = ent_valid[i] && (ent_addr[i] == lk_addr);
            fill_hit_vec[i] = ent_valid[i] && !ent_filled[i] && (ent_addr[i] == fill_addr);
            if (lk_hit_vec[i]) begin
                lk_hit     = 1'b1;
                lk_hit_idx = IW'(i);
            end
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_wake_fsm.sv
module mshr_wake_fsm
    import mshr_pkg::*;
#(
    parameter int N_ENTRIES = 16,
    parameter int N_WAIT    = 4,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int PW       = (N_WAIT > 1) ? $clog2(N_WAIT) : 1,
    localparam int CW       = $clog2(N_WAIT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] filled_vec,
    input  logic [CW-1:0]        sel_count,
    input  logic                 merge_into_sel,
    input  logic                 wk_ready,
    output logic                 wk_valid,
    output logic [IW-1:0]        sel_idx,
    output logic [PW-1:0]        rd_ptr,
    output logic                 release_sel
);
    wk_state_e     state_q, state_d;
    logic [IW-1:0] sel_d;
    logic [PW-1:0] rd_d;
    logic          pick_any;
    logic [IW-1:0] pick_idx;

    always_comb begin
        pick_any = 1'b0;
        pick_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (filled_vec[i]) begin
                pick_any = 1'b1;
                pick_idx = IW'(i);
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WK_IDLE;
            sel_idx <= '0;
            rd_ptr  <= '0;
        end else begin
            state_q <= state_d;
            sel_idx <= sel_d;
            rd_ptr  <= rd_d;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d     = state_q;
        sel_d       = sel_idx;
        rd_d        = rd_ptr;
        wk_valid    = 1'b0;
        release_sel = 1'b0;
        unique case (state_q)
            WK_IDLE: begin
                if (pick_any) begin
                    state_d = WK_SEND;
                    sel_d   = pick_idx;
                    rd_d    = '0;
                end
            end
            WK_SEND: begin
                wk_valid = 1'b1;
                if (wk_ready) begin
                    if ((CW'(rd_ptr) + CW'(1) == sel_count) && !merge_into_sel) begin
                        release_sel = 1'b1;
                        state_d     = WK_IDLE;
                    end else begin
                        rd_d = rd_ptr + PW'(1);
                    end
                end
            end
            default: state_d = WK_IDLE;
        endcase
    end

    // R7: wakeup held under backpressure
    a_r7_hold_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_valid && !wk_ready) |=> wk_valid);
    a_r7_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (wk_valid && !wk_ready) |=> ($stable(rd_ptr) && $stable(sel_idx)));
endmodule

// File: rtl/mshr_file.sv
module mshr_file #(
    parameter int N_ENTRIES = 16,
    parameter int N_WAIT    = 4,
    parameter int ADDR_W    = 26,
    parameter int TAG_W     = 6,
    localparam int IW       = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
    localparam int PW       = (N_WAIT > 1) ? $clog2(N_WAIT) : 1,
    localparam int CW       = $clog2(N_WAIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_stall,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              wk_valid,
    input  logic              wk_ready,
    output logic [TAG_W-1:0]  wk_tag
);
    logic [N_ENTRIES-1:0] ent_valid;
    logic [N_ENTRIES-1:0] ent_filled;
    logic [ADDR_W-1:0]    ent_addr  [N_ENTRIES];
    logic [CW-1:0]        ent_count [N_ENTRIES];
    logic [TAG_W-1:0]     ent_tags  [N_ENTRIES][N_WAIT];

    logic [N_ENTRIES-1:0] lk_hit_vec, fill_hit_vec;
    logic                 lk_hit, free_found;
    logic [IW-1:0]        lk_hit_idx, free_idx;
    logic [IW-1:0]        sel_idx;
    logic [PW-1:0]        rd_ptr;
    logic                 release_sel;
    logic                 do_alloc, do_merge, merge_into_sel;

    mshr_cam #(.N_ENTRIES(N_ENTRIES), .ADDR_W(ADDR_W)) u_cam (
        .ent_valid    (ent_valid),
        .ent_addr     (ent_addr),
        .ent_filled   (ent_filled),
        .lk_addr      (lk_addr),
        .fill_addr    (fill_addr),
        .lk_hit_vec   (lk_hit_vec),
        .lk_hit       (lk_hit),
        .lk_hit_idx   (lk_hit_idx),
        .fill_hit_vec (fill_hit_vec),
        .free_found   (free_found),
        .free_idx     (free_idx)
    );

    always_comb begin
        if (lk_hit) lk_stall = lk_valid && (ent_count[lk_hit_idx] == CW'(N_WAIT));
        else        lk_stall = lk_valid && !free_found;
        do_alloc       = lk_valid && !lk_hit && free_found;
        do_merge       = lk_valid && lk_hit && !lk_stall;
        merge_into_sel = do_merge && (lk_hit_idx == sel_idx);
    end

    mshr_wake_fsm #(.N_ENTRIES(N_ENTRIES), .N_WAIT(N_WAIT)) u_wake (
        .clk            (clk),
        .rst_n          (rst_n),
        .filled_vec     (ent_filled),
        .sel_count      (ent_count[sel_idx]),
        .merge_into_sel (merge_into_sel),
        .wk_ready       (wk_ready),
        .wk_valid       (wk_valid),
        .sel_idx        (sel_idx),
        .rd_ptr         (rd_ptr),
        .release_sel    (release_sel)
    );

    assign wk_tag = ent_tags[sel_idx][rd_ptr];

    // Entry storage; merge is applied before the fill flag so a same-cycle
    // lookup joins the waiter list that is about to be replayed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid  <= '0;
            ent_filled <= '0;
            for (int i = 0; i < N_ENTRIES; i++) ent_count[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (do_alloc && free_idx == IW'(i)) begin
                    ent_valid[i]      <= 1'b1;
                    ent_filled[i]     <= 1'b0;
                    ent_addr[i]       <= lk_addr;
                    ent_count[i]      <= CW'(1);
                    ent_tags[i][0]    <= lk_tag;
                end
                if (do_merge && lk_hit_idx == IW'(i)) begin
                    ent_tags[i][PW'(ent_count[i])] <= lk_tag;
                    ent_count[i] <= ent_count[i] + CW'(1);
                end
                if (fill_valid && fill_hit_vec[i]) ent_filled[i] <= 1'b1;
                if (release_sel && sel_idx == IW'(i)) begin
                    ent_valid[i]  <= 1'b0;
                    ent_filled[i] <= 1'b0;
                    ent_count[i]  <= '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
        end else begin
            mem_req_valid <= do_alloc;
            if (do_alloc) mem_req_addr <= lk_addr;
        end
    end

    // R1: a new line reaches memory on the next cycle
    a_r1_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_stall && !lk_hit) |=> (mem_req_valid && mem_req_addr == $past(lk_addr)));
    // R2: merging never requests memory
    a_r2_merge_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_stall && lk_hit) |=> !mem_req_valid);
    // R2: one entry per line
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));
    // R5: full storage stalls new lines
    a_r5_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit && (&ent_valid)) |-> lk_stall);
endmodule

// File: tb/tb_mshr_file.sv
module tb_mshr_file;
    localparam int N  = 4;
    localparam int W  = 3;
    localparam int AW = 8;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [AW-1:0] lk_addr = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          lk_stall;
    logic          mem_req_valid;
    logic [AW-1:0] mem_req_addr;
    logic          fill_valid = 1'b0;
    logic [AW-1:0] fill_addr = '0;
    logic          wk_valid;
    logic          wk_ready = 1'b1;
    logic [TW-1:0] wk_tag;

    always #5 clk = ~clk;

    mshr_file #(.N_ENTRIES(N), .N_WAIT(W), .ADDR_W(AW), .TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_tag(lk_tag), .lk_stall(lk_stall),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .wk_valid(wk_valid), .wk_ready(wk_ready), .wk_tag(wk_tag)
    );

    int n_vec = 0;
    int n_bad = 0;
    int req_n = 0;
    int wake_n = 0;
    int exp_wn = 0;
    int wake_chk = 0;
    logic [AW-1:0] req_log [512];
    logic [TW-1:0] wake_log [512];
    logic [TW-1:0] exp_wake [512];

    // Monitor away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid) begin req_log[req_n] = mem_req_addr; req_n++; end
            if (wk_valid && wk_ready) begin wake_log[wake_n] = wk_tag; wake_n++; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask

    task automatic lookup(input logic [AW-1:0] a, input logic [TW-1:0] t,
                          input bit exp_stall, input string req);
        lk_valid = 1'b1; lk_addr = a; lk_tag = t;
        #1 chk(lk_stall == exp_stall, req, int'(lk_stall), int'(exp_stall));
        tick();
        lk_valid = 1'b0;
    endtask

    task automatic fill(input logic [AW-1:0] a);
        fill_valid = 1'b1; fill_addr = a;
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic expect_wake(input logic [TW-1:0] t);
        exp_wake[exp_wn] = t; exp_wn++;
    endtask

    task automatic compare_wakes(input string req);
        chk(wake_n == exp_wn, req, wake_n, exp_wn);
        for (int k = wake_chk; k < exp_wn && k < wake_n; k++)
            chk(wake_log[k] == exp_wake[k], req, int'(wake_log[k]), int'(exp_wake[k]));
        wake_chk = exp_wn;
    endtask

    task automatic wait_n(input int c);
        for (int k = 0; k < c; k++) tick();
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int rbase;
        wait_n(3);
        rst_n = 1'b1;
        tick();
        // reset state
        chk(mem_req_valid == 1'b0, "R1 reset", int'(mem_req_valid), 0);
        chk(wk_valid == 1'b0, "R3 reset", int'(wk_valid), 0);
        chk(lk_stall == 1'b0, "R5 reset", int'(lk_stall), 0);

        // R1 primary, R2 merges, R4 slot full, R10 stalled lookup ignored
        lookup(8'h10, 6'd1, 1'b0, "R1");
        lookup(8'h10, 6'd2, 1'b0, "R2");
        lookup(8'h10, 6'd3, 1'b0, "R2");
        lookup(8'h10, 6'd4, 1'b1, "R4");
        wait_n(2);
        chk(req_n == 1, "R2 single request", req_n, 1);
        chk(req_log[0] == 8'h10, "R1 address", int'(req_log[0]), 16);

        // R6 overlapping misses, R5 full stall
        lookup(8'h20, 6'd5, 1'b0, "R6");
        lookup(8'h30, 6'd6, 1'b0, "R6");
        lookup(8'h40, 6'd7, 1'b0, "R6");
        lookup(8'h50, 6'd8, 1'b1, "R5");
        wait_n(2);
        chk(req_n == 4, "R6 requests", req_n, 4);
        chk(req_log[1] == 8'h20, "R6 order", int'(req_log[1]), 32);
        chk(req_log[3] == 8'h40, "R10 no request", int'(req_log[3]), 64);

        // R3 fill wakes all, R7 order, R10 stalled tag absent
        fill(8'h10);
        wait_n(8);
        expect_wake(6'd1); expect_wake(6'd2); expect_wake(6'd3);
        compare_wakes("R3 R7 R10");

        // R3 entry reusable after release
        lookup(8'h50, 6'd8, 1'b0, "R3 reuse");
        wait_n(2);
        chk(req_n == 5, "R3 reuse request", req_n, 5);
        chk(req_log[4] == 8'h50, "R3 reuse address", int'(req_log[4]), 80);

        // R8 same-cycle lookup and fill
        lk_valid = 1'b1; lk_addr = 8'h20; lk_tag = 6'd9;
        fill_valid = 1'b1; fill_addr = 8'h20;
        tick();
        lk_valid = 1'b0; fill_valid = 1'b0;
        wait_n(8);
        expect_wake(6'd5); expect_wake(6'd9);
        compare_wakes("R8");
        chk(req_n == 5, "R8 no request", req_n, 5);

        // R7 backpressure
        wk_ready = 1'b0;
        fill(8'h30);
        wait_n(3);
        chk(wk_valid == 1'b1, "R7 valid held", int'(wk_valid), 1);
        chk(wk_tag == 6'd6, "R7 tag held", int'(wk_tag), 6);
        wait_n(3);
        chk(wk_tag == 6'd6, "R7 tag still held", int'(wk_tag), 6);
        chk(wake_n == exp_wn, "R7 no handshake", wake_n, exp_wn);
        wk_ready = 1'b1;
        wait_n(4);
        expect_wake(6'd6);
        compare_wakes("R7 release");

        // R9 stray fills: unknown line, and a line already drained
        fill(8'h77);
        fill(8'h40);
        wait_n(6);
        fill(8'h40);
        wait_n(6);
        expect_wake(6'd7);
        compare_wakes("R9");

        // Sweep: lines 1..3 per round, 1..3 waiters each; E (0x50) stays pending.
        for (int r = 0; r < 6; r++) begin
            int nl;
            nl = 1 + (r % 3);
            rbase = req_n;
            for (int k = 0; k < nl; k++)
                for (int j = 0; j < 1 + ((k + r) % 3); j++)
                    lookup(AW'(8'h80 + r * 8 + k), TW'(r * 16 + k * 4 + j), 1'b0, "R6 sweep");
            wait_n(2);
            chk(req_n == rbase + nl, "R1 sweep requests", req_n - rbase, nl);
            if (r % 2 == 0) begin
                // back-to-back fills in allocation order: R11 no interleave
                for (int k = 0; k < nl; k++) fill(AW'(8'h80 + r * 8 + k));
                for (int k = 0; k < nl; k++)
                    for (int j = 0; j < 1 + ((k + r) % 3); j++)
                        expect_wake(TW'(r * 16 + k * 4 + j));
                wait_n(20);
            end else begin
                for (int k = nl - 1; k >= 0; k--) begin
                    fill(AW'(8'h80 + r * 8 + k));
                    wait_n(8);
                    for (int j = 0; j < 1 + ((k + r) % 3); j++)
                        expect_wake(TW'(r * 16 + k * 4 + j));
                end
            end
            compare_wakes("R11 sweep");
        end

        // R11: entry filled while another drains waits its turn
        wk_ready = 1'b0;
        lookup(8'hC0, 6'd40, 1'b0, "R11");
        lookup(8'hC0, 6'd41, 1'b0, "R11");
        lookup(8'hC8, 6'd42, 1'b0, "R11");
        fill(8'h50);
        wait_n(2);
        fill(8'hC8);
        fill(8'hC0);
        wk_ready = 1'b1;
        wait_n(12);
        expect_wake(6'd8); expect_wake(6'd40); expect_wake(6'd41); expect_wake(6'd42);
        compare_wakes("R11 ordering");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule